// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a small set of recently used page translations and turns a 20-bit virtual page number into a 20-bit physical frame number within the same cycle. Every valid entry compares its stored tag against the request at once. The lookup outputs are combinational from the request: hit, frame, a rights-violation flag, the entry's stored dirty bit, and a flag for multiple matches. A 32-bit address is split by the user into the page number (upper 20 bits) and the 12-bit offset, which bypasses the block.

When a lookup with `lk_req` asserted hits and is permitted, the entry's referenced bit is set. When that lookup is also a write, the entry's dirty bit is set as well. After a miss, the external page-table walker writes the missing translation through the refill port. The block picks the slot itself: first an empty slot, then a slot whose referenced bit is clear, and otherwise a round-robin slot. In that last case every referenced bit is cleared. A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is empty: any lookup gives `lk_hit`=0, `lk_pfn`=0, `lk_fault`=0, `lk_dirty`=0, `lk_multi`=0, and the round-robin pointer is at slot 0.
- R2: A lookup hits in the same cycle when a valid entry's tag equals `lk_vpn`, and `lk_pfn` gives that entry's frame. On a miss, `lk_pfn` is 0.
- R3: Rights are encoded as follows: bit 0 permits reads and bit 1 permits writes. `lk_fault` is 1 exactly when the lookup hits and the rights bit for the access type (`lk_write`=1 means write) is 0. A miss never faults.
- R4: A permitted hit with `lk_req`=1 sets the entry's referenced bit. If the access is also a write, it sets the entry's dirty bit. A faulting hit, or a lookup with `lk_req`=0, changes neither bit. `lk_dirty` shows the matched entry's stored dirty bit, and is 0 on a miss.
- R5: A refill (`fill_en`=1) writes tag, frame and rights into the lowest-numbered empty slot. The new entry is valid, with dirty and referenced bits clear, and it hits from the next cycle on.
- R6: When every slot is valid, a refill replaces the lowest-numbered slot whose referenced bit is clear.
- R7: When every slot is valid and referenced, a refill replaces the slot at the round-robin pointer. The pointer then advances by one, modulo the entry count, and every referenced bit is cleared, including one being set by a hit in that same cycle.
- R8: When two or more valid entries match, `lk_multi`=1 and `lk_hit`=1. Frame, rights and dirty then come from the lowest-numbered match, and only that entry is updated.
- R9: `flush`=1 makes every entry invalid from the next cycle on. A refill in the same cycle is dropped, and the pointer does not move.
- R10: When a refill replaces the entry that a lookup hits in the same cycle, the refill wins: the new entry starts with dirty and referenced bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_req | input | 1 | Lookup is a real access that may update status bits |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_hit | output | 1 | A valid entry matched |
| lk_pfn | output | 20 | Physical frame number of the match, 0 on miss |
| lk_fault | output | 1 | Hit whose rights forbid the access |
| lk_dirty | output | 1 | Stored dirty bit of the matched entry |
| lk_multi | output | 1 | More than one valid entry matched |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Tag of the new translation |
| fill_pfn | input | 20 | Frame of the new translation |
| fill_rights | input | 2 | Rights of the new translation (bit 0 read, bit 1 write) |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer completely and then touches chosen entries. This checks that replacement picks the lowest clear referenced bit. A design that scanned from the top, or ignored the referenced bit, would evict a translation that is still in use. The bench then saturates every referenced bit twice to check the round-robin step and the clearing of all referenced bits. A design that reset the pointer, or kept stale referenced bits, would keep replacing the same slot. Directed cycles also cover these cases:
- A duplicate tag, which must raise the multiple-match flag and return the lower slot's frame.
- A write to a read-only page, which must fault and leave the dirty bit clear.
- A flush in the same cycle as a refill, where the refill must not survive.
- A hit on the very entry being replaced, whose dirty bit must not carry into the new entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int RIGHTS_W = 2;
  localparam int RT_RD    = 0;
  localparam int RT_WR    = 1;

  typedef logic [RIGHTS_W-1:0] rights_t;

  function automatic logic access_ok(rights_t r, logic wr);
    return wr ? r[RT_WR] : r[RT_RD];
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VPN_W-1:0]        vpn,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [N-1:0]            valid,
  output logic                    hit,
  output logic                    multi,
  output logic [IDX_W-1:0]        sel
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == vpn);
  end

  assign hit   = |match;
  assign multi = |(match & (match - N'(1)));

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     refb,
  input  logic             fill_go,
  output logic [IDX_W-1:0] victim,
  output logic             clr_refs
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] inv_idx, unref_idx;
  logic             any_inv, any_unref;

  always_comb begin
    inv_idx   = '0;
    unref_idx = '0;
    any_inv   = 1'b0;
    any_unref = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_idx = IDX_W'(i);
        any_inv = 1'b1;
      end
      if (!refb[i]) begin
        unref_idx = IDX_W'(i);
        any_unref = 1'b1;
      end
    end
  end

  always_comb begin
    clr_refs = !any_inv && !any_unref;
    if (any_inv)        victim = inv_idx;
    else if (any_unref) victim = unref_idx;
    else                victim = rr_q;
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_go && clr_refs) begin
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rr_q <= '0;
    else         rr_q <= rr_d;
  end

  // R5
  empty_first_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    any_inv |-> !valid[victim]);
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_fault,
  output logic             lk_dirty,
  output logic             lk_multi,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [1:0]       fill_rights,
  input  logic             flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  rights_t [ENTRIES-1:0]         rt_q;
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            ref_q, ref_d;
  logic [ENTRIES-1:0]            dirty_q, dirty_d;

  logic             hit, multi, clr_refs, fill_go, ok;
  logic [IDX_W-1:0] sel, victim;

  assign fill_go = fill_en && !flush;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_match (
    .vpn(lk_vpn), .tags(tag_q), .valid(valid_q),
    .hit(hit), .multi(multi), .sel(sel)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_ns(rst_ns), .valid(valid_q), .refb(ref_q),
    .fill_go(fill_go), .victim(victim), .clr_refs(clr_refs)
  );

  assign ok       = access_ok(rt_q[sel], lk_write);
  assign lk_hit   = hit;
  assign lk_multi = multi;
  assign lk_pfn   = hit ? pfn_q[sel] : '0;
  assign lk_fault = hit && !ok;
  assign lk_dirty = hit && dirty_q[sel];

  always_comb begin
    valid_d = valid_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (lk_req && hit && ok) begin
      ref_d[sel] = 1'b1;
      if (lk_write) dirty_d[sel] = 1'b1;
    end
    if (fill_go && clr_refs) ref_d = '0;
    if (fill_go) begin
      valid_d[victim] = 1'b1;
      ref_d[victim]   = 1'b0;
      dirty_d[victim] = 1'b0;
    end
    if (flush) valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[victim] <= fill_vpn;
      pfn_q[victim] <= fill_pfn;
      rt_q[victim]  <= fill_rights;
    end
  end

  // R3
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    lk_fault |-> lk_hit);
  // R8
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    lk_multi |-> lk_hit);
  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !lk_hit |-> (lk_pfn == '0 && !lk_dirty));
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(flush) |-> !lk_hit);
  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(fill_en) && !$past(flush) && !$past(lk_multi) && lk_vpn == $past(fill_vpn)) |-> lk_hit);
endmodule

// File: tb/tb_tlb_xlat.sv
module tb_tlb_xlat;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0, lk_write = 1'b0, fill_en = 1'b0, flush = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0;
  logic [1:0]  fill_rights = '0;
  logic        lk_hit, lk_fault, lk_dirty, lk_multi;
  logic [19:0] lk_pfn;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic [1:0]  m_rt  [N];
  logic        m_v [N], m_r [N], m_d [N];
  int          m_rr;

  always #(CLK_P/2) clk = ~clk;

  tlb_xlat dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault), .lk_dirty(lk_dirty),
    .lk_multi(lk_multi), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_rights(fill_rights), .flush(flush)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] v, output int cnt);
    int idx = -1;
    cnt = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == v) begin
        if (idx < 0) idx = i;
        cnt++;
      end
    return idx;
  endfunction

  function automatic int m_victim(output bit clr);
    clr = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_r[i]) return i;
    clr = 1;
    return m_rr;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_r[i] = 0; m_d[i] = 0;
      m_vpn[i] = '0; m_pfn[i] = '0; m_rt[i] = '0;
    end
    m_rr = 0;
  endtask

  task automatic cyc(input logic req, input logic wr, input logic [19:0] vpn,
                     input logic fen, input logic [19:0] fv, input logic [19:0] fp,
                     input logic [1:0] frt, input logic fl);
    int idx, cnt, vic;
    bit clr, ok, e_hit;
    logic [19:0] e_pfn;
    @(negedge clk);
    lk_req = req; lk_write = wr; lk_vpn = vpn;
    fill_en = fen; fill_vpn = fv; fill_pfn = fp; fill_rights = frt; flush = fl;
    #1;
    idx   = m_find(vpn, cnt);
    e_hit = (idx >= 0);
    ok    = e_hit && (wr ? m_rt[idx][1] : m_rt[idx][0]);
    e_pfn = e_hit ? m_pfn[idx] : '0;
    chk(lk_hit == e_hit, "R2 hit", 32'(lk_hit), 32'(e_hit));
    chk(lk_pfn == e_pfn, "R2 pfn", 32'(lk_pfn), 32'(e_pfn));
    chk(lk_fault == (e_hit && !ok), "R3 fault", 32'(lk_fault), 32'(e_hit && !ok));
    chk(lk_dirty == (e_hit && m_d[idx < 0 ? 0 : idx]), "R4 dirty", 32'(lk_dirty),
        32'(e_hit && m_d[idx < 0 ? 0 : idx]));
    chk(lk_multi == (cnt > 1), "R8 multi", 32'(lk_multi), 32'(cnt > 1));
    vic = m_victim(clr);
    @(posedge clk);
    if (req && e_hit && ok) begin
      m_r[idx] = 1;
      if (wr) m_d[idx] = 1;
    end
    if (fen && !fl) begin
      if (clr) begin
        for (int i = 0; i < N; i++) m_r[i] = 0;
        m_rr = (m_rr + 1) % N;
      end
      m_v[vic] = 1; m_r[vic] = 0; m_d[vic] = 0;
      m_vpn[vic] = fv; m_pfn[vic] = fp; m_rt[vic] = frt;
    end
    if (fl) for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic look(input logic [19:0] v, input logic req, input logic wr);
    cyc(req, wr, v, 0, '0, '0, '0, 0);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] rt);
    cyc(0, 0, '0, 1, v, p, rt, 0);
  endtask

  task automatic probe(input logic [19:0] v, input string tag, input bit e_hit);
    @(negedge clk);
    lk_req = 0; lk_write = 0; lk_vpn = v; fill_en = 0; flush = 0;
    #1;
    chk(lk_hit == e_hit, tag, 32'(lk_hit), 32'(e_hit));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1f3a;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: empty after reset
    @(negedge clk); lk_vpn = 20'h00000; #1;
    chk(!lk_hit && lk_pfn == 0 && !lk_fault && !lk_dirty && !lk_multi, "R1 reset state",
        {lk_hit, lk_fault, lk_dirty, lk_multi}, 0);
    look(20'h12345, 1, 1);

    // R5: sixteen fills land in empty slots, none overwritten
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 20'hA000 + 20'(i), 2'b11);
    for (int i = 0; i < N; i++) probe(20'h100 + 20'(i), "R5 fill kept", 1);

    // R6: entries 0..2 referenced, next fill evicts entry 3
    for (int i = 0; i < 3; i++) look(20'h100 + 20'(i), 1, 0);
    fill(20'h200, 20'hB000, 2'b11);
    probe(20'h103, "R6 first unreferenced evicted", 0);
    probe(20'h100, "R6 referenced kept", 1);
    probe(20'h104, "R6 later kept", 1);

    // R7: all referenced -> pointer slot 0, then slot 1
    for (int i = 0; i < N; i++) look(m_vpn[i], 1, 0);
    fill(20'h300, 20'hC000, 2'b11);
    probe(20'h100, "R7 pointer slot 0 evicted", 0);
    probe(20'h101, "R7 others kept", 1);
    for (int i = 0; i < N; i++) look(m_vpn[i], 1, 0);
    fill(20'h301, 20'hC001, 2'b11);
    probe(20'h101, "R7 pointer advanced to slot 1", 0);
    probe(20'h300, "R7 slot 0 kept", 1);
    // refs were cleared: next fill takes lowest unreferenced (slot 0)
    fill(20'h302, 20'hC002, 2'b11);
    probe(20'h300, "R7 referenced bits cleared", 0);

    // R10: write hit on victim (slot 0) while refill replaces it
    cyc(1, 1, 20'h302, 1, 20'h303, 20'hC003, 2'b11, 0);
    probe(20'h302, "R10 old tag gone", 0);
    @(negedge clk); lk_vpn = 20'h303; #1;
    chk(lk_hit && !lk_dirty, "R10 refill wins, dirty clear", {lk_hit, lk_dirty}, 32'h2);

    // R9: flush with simultaneous fill
    cyc(0, 0, '0, 1, 20'h400, 20'hD000, 2'b11, 1);
    probe(20'h400, "R9 fill dropped by flush", 0);
    probe(20'h303, "R9 entries invalid", 0);

    // R8: duplicate tag
    fill(20'h500, 20'h00001, 2'b11);
    fill(20'h500, 20'h00002, 2'b11);
    @(negedge clk); lk_vpn = 20'h500; #1;
    chk(lk_multi && lk_hit && lk_pfn == 20'h1, "R8 duplicate lowest slot", lk_pfn, 1);

    // R3/R4: write to read-only page faults and leaves dirty clear
    fill(20'h600, 20'hE000, 2'b01);
    look(20'h600, 1, 1);
    @(negedge clk); lk_vpn = 20'h600; lk_write = 1; #1;
    chk(lk_fault && !lk_dirty, "R4 faulting write keeps dirty clear", {lk_fault, lk_dirty}, 32'h2);
    look(20'h600, 1, 0);
    fill(20'h601, 20'hE001, 2'b10);
    look(20'h601, 1, 0);
    look(20'h601, 1, 1);
    look(20'h601, 1, 0);
    look(20'h601, 0, 1);
    cyc(0, 0, '0, 0, '0, '0, '0, 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [19:0] v;
      op = int'($urandom_range(0, 99));
      v  = 20'h700 + 20'($urandom_range(0, 39));
      if (op < 3)
        cyc(0, 0, '0, 0, '0, '0, '0, 1);
      else if (op < 30)
        cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            20'h700 + 20'($urandom_range(0, 39)), 1, v, 20'($urandom), 2'($urandom), 0);
      else
        cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), v, 0, '0, '0, '0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule